// File: doc/BRIEF.md
# Reliable Packet Sender with Acknowledge Timeout

This block is the transmit engine of a network interface that must not lose packets. A packet comes in as a byte stream: the first byte is the header, with the destination in bits [7:4] and the packet type in bits [3:0], and the bytes after it are payload. While the bytes are accepted, the engine writes them into a retransmit buffer and keeps a running 8-bit sum. It then sends the stored bytes one per cycle and closes the frame with a check byte. After the check byte it waits for an acknowledgement, counting cycles. A matching acknowledgement releases the buffer. If the wait runs out first, the stored copy is sent again and the count starts over. Only one packet is in flight at a time. After a set number of resends the packet is dropped and an error flag is raised.

The same module also contains the receive-side checker. It adds up every byte of an incoming frame, trailer included. When the total is zero modulo 256, it returns an acknowledgement that carries the frame's sequence tag. A one-bit tag travels beside each frame, so an acknowledgement meant for an earlier packet cannot release the current one. In a system the transmit outputs go to a link, the receive inputs come from the far end's link, and the acknowledgement returns on a separate path.

Top module: `reliable_link`

## Requirements
- R1: After reset, in_ready is 1 and tx_valid, drop_err and rx_ack are 0.
- R2: Bytes are accepted on cycles with in_valid and in_ready both high. in_ready goes low right after the byte that carries in_last, or after the DEPTH-th byte of a packet, whichever comes first. That byte ends the packet.
- R3: A frame consists of the stored bytes, in order, on consecutive cycles, followed by a trailer byte equal to the two's-complement negation of the 8-bit sum of those bytes, so the whole frame sums to 0 modulo 256. tx_last is high only on the trailer byte.
- R4: tx_seq stays constant over every transmission of one packet. It is 0 for the first packet after reset and toggles between consecutive packets, whether a packet ends by acknowledgement or by drop.
- R5: In a waiting cycle after a trailer, an ack_valid whose ack_seq equals tx_seq ends the packet: in_ready is 1 in the next cycle and the frame is not sent again. When rx_ack is looped back to ack_valid, in_ready rises 2 cycles after the trailer cycle.
- R6: An ack_valid whose ack_seq differs from tx_seq has no effect: in_ready stays 0 and the resend still happens on time.
- R7: If no matching acknowledgement arrives within TIMEOUT waiting cycles, the first byte of the resent frame appears TIMEOUT+1 cycles after the previous trailer cycle.
- R8: If the first transmission and MAX_RETRY resends all go unacknowledged, the packet is dropped after 1+MAX_RETRY frames. in_ready and drop_err both rise TIMEOUT+1 cycles after the last trailer cycle.
- R9: drop_err stays 1 until the first byte of the next packet is accepted, and is 0 from the following cycle on.
- R10: rx_ack is a one-cycle pulse in the cycle after an rx_last byte that brings the frame's byte sum to 0 modulo 256, and rx_ack_seq then equals the rx_seq of that byte. A frame with a different sum produces no rx_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Packet byte offered |
| in_data | input | 8 | Packet byte (first byte is the header) |
| in_last | input | 1 | Offered byte is the last of the packet |
| in_ready | output | 1 | Engine accepts packet bytes |
| tx_valid | output | 1 | Link byte valid |
| tx_data | output | 8 | Link byte |
| tx_last | output | 1 | Link byte is the check trailer |
| tx_seq | output | 1 | Sequence tag of the frame on the link |
| ack_valid | input | 1 | Acknowledgement arrives |
| ack_seq | input | 1 | Sequence tag of the acknowledgement |
| drop_err | output | 1 | Last packet was abandoned after all retries |
| rx_valid | input | 1 | Incoming link byte valid |
| rx_data | input | 8 | Incoming link byte |
| rx_last | input | 1 | Incoming byte is the trailer |
| rx_seq | input | 1 | Sequence tag of the incoming frame |
| rx_ack | output | 1 | Checker acknowledges a good frame |
| rx_ack_seq | output | 1 | Tag of the acknowledged frame |

## Verification
The first frame byte appears in the cycle after the last accepted input byte. With loopback, rx_ack comes one cycle after the trailer, and in_ready comes two cycles after it. A resend starts TIMEOUT+1 cycles after a trailer, and a drop shows up that same number of cycles after the final trailer. A monitor samples on the falling edge and records the cycle numbers of trailers, first bytes and in_ready rises. The checks compare these cycle numbers as differences, and the bench reads the recorded values only after the next rising edge, so no read races the monitor. Stale and matching acknowledgements are injected in the first waiting cycle after a trailer. This keeps each injection inside the window that R5 and R6 describe.

// File: rtl/reliable_link.sv
module reliable_link #(
  parameter int DEPTH     = 16,
  parameter int TIMEOUT   = 20,
  parameter int MAX_RETRY = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_last,
  output logic       in_ready,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  output logic       tx_last,
  output logic       tx_seq,
  input  logic       ack_valid,
  input  logic       ack_seq,
  output logic       drop_err,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  input  logic       rx_last,
  input  logic       rx_seq,
  output logic       rx_ack,
  output logic       rx_ack_seq
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);
  localparam int TW = $clog2(TIMEOUT + 1);
  localparam int RW = $clog2(MAX_RETRY + 2);

  typedef enum logic [1:0] {S_LOAD, S_SEND, S_WAIT} state_t;

  state_t        st;
  logic [7:0]    mem [DEPTH];
  logic [LW-1:0] wcnt, len, idx;
  logic [7:0]    sum, csum, rsum;
  logic [TW-1:0] tmr;
  logic [RW-1:0] tries;
  logic          seq, err;
  logic          take, close_in, ack_hit, expire;

  assign in_ready = (st == S_LOAD);
  assign take     = in_ready && in_valid;
  assign close_in = in_last || (wcnt == LW'(DEPTH - 1));
  assign ack_hit  = (st == S_WAIT) && ack_valid && (ack_seq == seq);
  assign expire   = (st == S_WAIT) && (tmr == TW'(TIMEOUT - 1));

  assign tx_valid = (st == S_SEND);
  assign tx_last  = tx_valid && (idx == len);
  assign tx_data  = (idx == len) ? csum : mem[idx[AW-1:0]];
  assign tx_seq   = seq;
  assign drop_err = err;

  always_ff @(posedge clk) begin
    if (take) mem[wcnt[AW-1:0]] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_LOAD;
      wcnt  <= '0;
      len   <= '0;
      idx   <= '0;
      sum   <= '0;
      csum  <= '0;
      tmr   <= '0;
      tries <= '0;
      seq   <= 1'b0;
      err   <= 1'b0;
    end else begin
      unique case (st)
        S_LOAD: if (in_valid) begin
          if (wcnt == '0) err <= 1'b0;
          if (close_in) begin
            len   <= wcnt + LW'(1);
            csum  <= 8'd0 - 8'(sum + in_data);
            idx   <= '0;
            tries <= '0;
            wcnt  <= '0;
            sum   <= '0;
            st    <= S_SEND;
          end else begin
            wcnt <= wcnt + LW'(1);
            sum  <= 8'(sum + in_data);
          end
        end
        S_SEND: begin
          if (idx == len) begin
            tmr <= '0;
            st  <= S_WAIT;
          end else begin
            idx <= idx + LW'(1);
          end
        end
        S_WAIT: begin
          if (ack_hit) begin
            seq <= ~seq;
            st  <= S_LOAD;
          end else if (expire) begin
            if (tries == RW'(MAX_RETRY)) begin
              seq <= ~seq;
              err <= 1'b1;
              st  <= S_LOAD;
            end else begin
              tries <= tries + RW'(1);
              idx   <= '0;
              st    <= S_SEND;
            end
          end else begin
            tmr <= tmr + TW'(1);
          end
        end
        default: st <= S_LOAD;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsum       <= '0;
      rx_ack     <= 1'b0;
      rx_ack_seq <= 1'b0;
    end else begin
      rx_ack <= 1'b0;
      if (rx_valid) begin
        if (rx_last) begin
          rx_ack     <= (8'(rsum + rx_data) == 8'd0);
          rx_ack_seq <= rx_seq;
          rsum       <= '0;
        end else begin
          rsum <= 8'(rsum + rx_data);
        end
      end
    end
  end
endmodule

// File: rtl/reliable_link_chk.sv
module reliable_link_chk (
  input logic clk,
  input logic rst_n,
  input logic in_ready,
  input logic tx_valid,
  input logic tx_last,
  input logic tx_seq,
  input logic ack_valid,
  input logic ack_seq,
  input logic drop_err,
  input logic rx_valid,
  input logic rx_last,
  input logic rx_ack
);
  AST_FRAME_GAPLESS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_last |=> tx_valid); // R3
  AST_QUIET_AFTER_TRAILER: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |=> !tx_valid); // R7
  AST_NO_INPUT_WHILE_SENDING: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !in_ready); // R2
  AST_SEQ_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && $past(tx_valid) |-> tx_seq == $past(tx_seq)); // R4
  AST_DROP_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drop_err) |-> in_ready); // R8
  AST_ACK_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ack |-> $past(rx_valid && rx_last)); // R10
  AST_ACK_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid && (ack_seq == tx_seq) && !in_ready && !tx_valid |=> in_ready); // R5
endmodule

bind reliable_link reliable_link_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .tx_valid(tx_valid),
  .tx_last(tx_last), .tx_seq(tx_seq), .ack_valid(ack_valid), .ack_seq(ack_seq),
  .drop_err(drop_err), .rx_valid(rx_valid), .rx_last(rx_last), .rx_ack(rx_ack)
);

// File: tb/tb_reliable_link.sv
module tb_reliable_link;
  localparam int DEPTH = 16, TIMEOUT = 20, MAX_RETRY = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic       in_valid = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready, tx_valid, tx_last, tx_seq, drop_err;
  logic [7:0] tx_data, rx_data;
  logic       ack_valid, ack_seq, rx_valid, rx_last, rx_seq, rx_ack, rx_ack_seq;

  logic block_ack = 1'b0, inj_valid = 1'b0, inj_seq = 1'b0, txv_q = 1'b0;
  int   corrupt_frames = 0;

  reliable_link #(.DEPTH(DEPTH), .TIMEOUT(TIMEOUT), .MAX_RETRY(MAX_RETRY)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_ready(in_ready), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_last(tx_last), .tx_seq(tx_seq),
    .ack_valid(ack_valid), .ack_seq(ack_seq), .drop_err(drop_err),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
    .rx_seq(rx_seq), .rx_ack(rx_ack), .rx_ack_seq(rx_ack_seq)
  );

  assign rx_valid  = tx_valid;
  assign rx_last   = tx_last;
  assign rx_seq    = tx_seq;
  assign rx_data   = tx_data ^ (((corrupt_frames > 0) && tx_valid && !txv_q) ? 8'h80 : 8'h00);
  assign ack_valid = (rx_ack && !block_ack) || inj_valid;
  assign ack_seq   = inj_valid ? inj_seq : rx_ack_seq;

  int checks = 0, fails = 0, cyc = 0;
  always @(posedge clk) begin
    cyc   <= cyc + 1;
    txv_q <= tx_valid;
  end

  logic [7:0] cap [DEPTH+1];
  int   cap_n = 0, frames = 0, acks = 0, trail_cyc = 0, gap = 0, rdy_cyc = 0;
  logic rdy_q = 1'b1, frame_seq = 1'b0;
  always @(negedge clk) begin
    if (tx_valid) begin
      if (!txv_q) begin
        cap_n = 0;
        frame_seq = tx_seq;
        if (frames > 0) gap = cyc - trail_cyc;
      end
      if (cap_n <= DEPTH) cap[cap_n] = tx_data;
      cap_n++;
      if (tx_last) begin
        frames++;
        trail_cyc = cyc;
        if (corrupt_frames > 0) corrupt_frames--;
      end
    end
    if (rx_ack) acks++;
    if (in_ready && !rdy_q) rdy_cyc = cyc;
    rdy_q = in_ready;
  end

  logic [7:0] pkt [DEPTH];
  logic       exp_seq = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] trailer_of(input int n);
    logic [7:0] s = 8'h00;
    for (int i = 0; i < n; i++) s = s + pkt[i];
    return 8'h00 - s;
  endfunction

  task automatic fill(input int n);
    pkt[0] = {4'($urandom % 16), 4'($urandom % 16)};
    for (int i = 1; i < n; i++) pkt[i] = 8'($urandom);
  endtask

  task automatic push(input int n, input bit with_last);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1;
      in_data  = pkt[i];
      in_last  = with_last && (i == n - 1);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic wait_ready();
    int k = 0;
    @(negedge clk);
    while (!in_ready && k < 5000) begin
      @(negedge clk);
      k++;
    end
    @(posedge clk);
    #1;
  endtask

  task automatic wait_frames(input int k);
    do @(posedge clk); while (frames < k);
    #1;
  endtask

  task automatic cmp_frame(input string req, input int n);
    int bad = 0;
    chk({req, " frame length"}, cap_n, n + 1);
    for (int i = 0; i < n; i++) if (cap[i] !== pkt[i]) bad++;
    chk({req, " payload mismatches"}, bad, 0);
    chk({req, " trailer"}, int'(cap[n]), int'(trailer_of(n)));
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic plain_packet(input int n, input int bad_frames);
    fill(n);
    frames = 0;
    acks = 0;
    corrupt_frames = bad_frames;
    push(n, 1'b1);
    chk("R2 in_ready low after last byte", int'(in_ready), 0);
    wait_ready();
    cmp_frame("R3", n);
    chk("R5 frames sent", frames, 1 + bad_frames);
    chk("R4 frame seq", int'(frame_seq), int'(exp_seq));
    chk("R5 ready delay after trailer", rdy_cyc - trail_cyc, 2);
    chk("R10 acks from checker", acks, 1);
    chk("R9 no drop", int'(drop_err), 0);
    if (bad_frames > 0) chk("R7 resend gap", gap, TIMEOUT + 1);
    exp_seq = ~exp_seq;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 in_ready", int'(in_ready), 1);
    chk("R1 tx_valid", int'(tx_valid), 0);
    chk("R1 drop_err", int'(drop_err), 0);
    chk("R1 rx_ack", int'(rx_ack), 0);
    rst_n = 1'b1;

    plain_packet(1, 0);
    plain_packet(DEPTH, 0);
    for (int t = 0; t < 8; t++) plain_packet(1 + int'($urandom % DEPTH), int'($urandom % 2));

    plain_packet(5, 1);

    fill(DEPTH);
    for (int i = 0; i < DEPTH; i++) pkt[i] = 8'hFF;
    frames = 0;
    push(DEPTH, 1'b0);
    chk("R2 buffer full ends packet", int'(in_ready), 0);
    wait_ready();
    cmp_frame("R2 R3 full buffer", DEPTH);
    exp_seq = ~exp_seq;

    fill(7);
    frames = 0;
    acks = 0;
    block_ack = 1'b1;
    push(7, 1'b1);
    wait_ready();
    chk("R8 frames before drop", frames, 1 + MAX_RETRY);
    chk("R8 drop_err", int'(drop_err), 1);
    chk("R8 drop delay", rdy_cyc - trail_cyc, TIMEOUT + 1);
    chk("R10 good frames acked", acks, 1 + MAX_RETRY);
    chk("R8 R3 last attempt intact", cap_n, 8);
    exp_seq = ~exp_seq;
    block_ack = 1'b0;
    repeat (5) @(negedge clk);
    chk("R9 drop_err held", int'(drop_err), 1);
    fill(3);
    frames = 0;
    push(3, 1'b1);
    chk("R9 drop_err cleared", int'(drop_err), 0);
    wait_ready();
    chk("R4 seq after drop", int'(frame_seq), int'(exp_seq));
    exp_seq = ~exp_seq;

    fill(4);
    frames = 0;
    block_ack = 1'b1;
    push(4, 1'b1);
    wait_frames(1);
    @(negedge clk);
    inj_valid = 1'b1;
    inj_seq = ~exp_seq;
    @(negedge clk);
    inj_valid = 1'b0;
    chk("R6 stale ack ignored", int'(in_ready), 0);
    wait_frames(2);
    chk("R6 resend after stale ack", gap, TIMEOUT + 1);
    @(negedge clk);
    inj_valid = 1'b1;
    inj_seq = exp_seq;
    @(negedge clk);
    inj_valid = 1'b0;
    chk("R5 matching ack frees", int'(in_ready), 1);
    repeat (TIMEOUT + 5) @(posedge clk);
    #1;
    chk("R5 no resend after ack", frames, 2);
    block_ack = 1'b0;
    exp_seq = ~exp_seq;

    plain_packet(9, 0);

    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end
endmodule